// File: doc/BRIEF.md
# Cell Bus Word Parity Monitor

This block watches a UTOPIA-style cell bus and checks the parity of each word that is marked valid. A single control input picks a 16-bit or an 8-bit bus. A second control input picks the parity sense, odd or even. Each failing word is counted in an internal 12-bit counter.

The count is never shown to software directly. Software writes a 16-bit status register with the capture bit set, and the current count is then copied into a snapshot field of that register. The same register holds two sticky flags. One records that a parity error has occurred. The other records that the counter has wrapped. Software clears each flag on its own by writing 0 to that flag's bit. Cell framing and loopback routing belong to other blocks.

The parity result passes through one register stage before it reaches the counter and the flags. An error on a word sampled at clock edge e therefore appears at edge e+1.

Top module: `parity_err_monitor`

## Requirements
- R1: With `even_sense`=0 (odd parity), a valid word is in error when the covered data bits plus `bus_par` hold an even number of ones. A word with an odd number of ones passes.
- R2: With `even_sense`=1 (even parity), a valid word is in error when the covered data bits plus `bus_par` hold an odd number of ones.
- R3: With `narrow_bus`=1, only `bus_data[7:0]` is covered and bits 15:8 have no effect. With `narrow_bus`=0, all 16 bits are covered.
- R4: A word sampled while `bus_valid`=0 is never counted and never sets a flag.
- R5: Read bit 12 is a sticky error flag. Hardware sets it for every counted error. A register write with bit 12 = 0 clears it, and a write with bit 12 = 1 leaves it as it is. When a clear and a hardware set fall in the same cycle, the set wins.
- R6: The internal counter is 12 bits wide and wraps from 4095 to 0. The wrap sets the sticky flag at read bit 13. That flag is cleared by a write with bit 13 = 0, with the hardware set winning in the same cycle.
- R7: A write with bit 14 = 1 copies the counter into read bits 11:0. A write with bit 14 = 0 leaves bits 11:0 unchanged. A capture does not clear the counter. Software cannot write bits 11:0 directly.
- R8: When an error reaches the counter in the same cycle as a capture, the snapshot takes the value from before that error, and the error is then added to the counter.
- R9: Read bits 15 and 14 are always 0.
- R10: Synchronous active-high `rst` clears the counter, both flags, the snapshot and the parity pipeline.
- R11: An error on a word sampled at edge e changes the count and flags at edge e+1. `reg_rdata` reflects the register state with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 16 | Cell bus data word |
| bus_par | input | 1 | Parity bit sent with the word |
| bus_valid | input | 1 | Word transfer strobe |
| narrow_bus | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| even_sense | input | 1 | 1 = even parity, 0 = odd parity |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Write data (bit 14 capture, bit 13 rollover keep, bit 12 error keep) |
| reg_rdata | output | 16 | Status register read value |

## Verification
The bench forces a capture in the same cycle as a pending error. A design that counted the error first would show a snapshot one too high. It runs 4096 errors in a row to make the counter wrap. An off-by-one wrap, or a rollover flag that misses the wrap, would show up as a wrong snapshot or a flag that stays low. It issues flag clears in the same cycle as hardware sets, so a design that let the clear win would drop an error flag that should stay set. In 8-bit mode it toggles the upper byte with bad parity there, so a design that still covered those bits would count errors that should not exist.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   localparam int REG_W    = 16;
   localparam int SNAP_LSB = 0;
   localparam int ERR_BIT  = 12;
   localparam int ROLL_BIT = 13;
   localparam int CAP_BIT  = 14;

   typedef struct packed {
      logic keep_err;
      logic keep_roll;
      logic capture;
   } pmon_wr_t;
endpackage

// File: rtl/pmon_parity_check.sv
module pmon_parity_check #(
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int PIPE_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data,
   input  logic              par,
   input  logic              valid,
   input  logic              narrow,
   input  logic              even,
   output logic              err_o
);
   logic [DATA_W-1:0] covered;
   logic              err_now;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < NARROW_W) begin : g_low
         assign covered[i] = data[i];
      end else begin : g_high
         assign covered[i] = data[i] & ~narrow;
      end
   end

   assign err_now = valid & ~((^covered) ^ par ^ even);

   if (PIPE_STAGES == 0) begin : g_nopipe
      assign err_o = err_now;
   end else begin : g_pipe
      logic [PIPE_STAGES-1:0] stage;
      always_ff @(posedge clk) begin
         if (rst) stage <= '0;
         else     stage <= {stage[PIPE_STAGES-1:0] << 1} | PIPE_STAGES'(err_now);
      end
      assign err_o = stage[PIPE_STAGES-1];

      AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
         !valid |=> !stage[0]);  // R4
   end
endmodule

// File: rtl/pmon_err_counter.sv
module pmon_err_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assign wrap = inc && (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
      inc && (cnt == CNT_MAX) |=> cnt == '0);  // R6
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt));  // R4
endmodule

// File: rtl/pmon_status_reg.sv
module pmon_status_reg
   import pmon_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             err_evt,
   input  logic             wrap_evt,
   output logic [REG_W-1:0] rdata
);
   pmon_wr_t         cmd;
   logic [CNT_W-1:0] snap;
   logic             flag_err;
   logic             flag_roll;
   logic             unused_wbits;

   assign cmd.keep_err  = wdata[ERR_BIT];
   assign cmd.keep_roll = wdata[ROLL_BIT];
   assign cmd.capture   = wdata[CAP_BIT];
   assign unused_wbits  = ^{wdata[REG_W-1], wdata[ERR_BIT-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         snap      <= '0;
         flag_err  <= 1'b0;
         flag_roll <= 1'b0;
      end else begin
         if (wr && cmd.capture) snap <= cnt;
         if (err_evt)                    flag_err <= 1'b1;
         else if (wr && !cmd.keep_err)   flag_err <= 1'b0;
         if (wrap_evt)                   flag_roll <= 1'b1;
         else if (wr && !cmd.keep_roll)  flag_roll <= 1'b0;
      end
   end

   always_comb begin
      rdata                          = '0;
      rdata[SNAP_LSB +: CNT_W]       = snap;
      rdata[ERR_BIT]                 = flag_err;
      rdata[ROLL_BIT]                = flag_roll;
   end

   AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
      err_evt |=> flag_err);  // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag_err && !(wr && !wdata[ERR_BIT]) |=> flag_err);  // R5
   AST_ROLL_SET: assert property (@(posedge clk) disable iff (rst)
      wrap_evt |=> flag_roll);  // R6
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
      wr && wdata[CAP_BIT] |=> snap == $past(cnt));  // R8
   AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(wr && wdata[CAP_BIT]) |=> $stable(snap));  // R7
endmodule

// File: rtl/parity_err_monitor.sv
module parity_err_monitor
   import pmon_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int CNT_W       = 12,
   parameter int PIPE_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_par,
   input  logic              bus_valid,
   input  logic              narrow_bus,
   input  logic              even_sense,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata
);
   if (NARROW_W <= 0 || NARROW_W >= DATA_W) begin : g_bad_narrow
      $error("NARROW_W must lie strictly between 0 and DATA_W");
   end
   if (CNT_W <= 0 || CNT_W > ERR_BIT) begin : g_bad_cnt
      $error("CNT_W must fit below the error flag bit");
   end
   if (PIPE_STAGES < 0 || PIPE_STAGES > 4) begin : g_bad_pipe
      $error("PIPE_STAGES must be 0 to 4");
   end

   logic             err_evt;
   logic             wrap_evt;
   logic [CNT_W-1:0] cnt;

   pmon_parity_check #(
      .DATA_W(DATA_W), .NARROW_W(NARROW_W), .PIPE_STAGES(PIPE_STAGES)
   ) u_check (
      .clk(clk), .rst(rst), .data(bus_data), .par(bus_par), .valid(bus_valid),
      .narrow(narrow_bus), .even(even_sense), .err_o(err_evt)
   );

   pmon_err_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst(rst), .inc(err_evt), .cnt(cnt), .wrap(wrap_evt)
   );

   pmon_status_reg #(.CNT_W(CNT_W)) u_status (
      .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .cnt(cnt),
      .err_evt(err_evt), .wrap_evt(wrap_evt), .rdata(reg_rdata)
   );

   AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> reg_rdata[REG_W-1:CAP_BIT] == '0);  // R9
endmodule

// File: tb/test_parity_err_monitor.sv
module test_parity_err_monitor;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_data = '0;
   logic        bus_par = 1'b0;
   logic        bus_valid = 1'b0;
   logic        narrow_bus = 1'b0;
   logic        even_sense = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_req = "R10";

   // reference model state
   int cnt_m = 0;
   bit ferr_m = 0, froll_m = 0, pend_m = 0;
   int snap_m = 0;

   always #5 clk = ~clk;

   parity_err_monitor i_parity_err_monitor (
      .clk(clk), .rst(rst), .bus_data(bus_data), .bus_par(bus_par),
      .bus_valid(bus_valid), .narrow_bus(narrow_bus), .even_sense(even_sense),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic bit word_err(logic [15:0] d, logic p, logic v, logic n, logic e);
      int ones = $countones(n ? {8'h00, d[7:0]} : d) + int'(p);
      if (!v) return 0;
      return e ? (ones % 2 == 1) : (ones % 2 == 0);
   endfunction

   function automatic logic par_for(logic [15:0] d, logic n, logic e, bit good);
      int  ones = $countones(n ? {8'h00, d[7:0]} : d);
      bit  want = e ? 1'b0 : 1'b1;  // wanted total parity for a good word
      if (!good) want = ~want;
      return want ^ ones[0];
   endfunction

   always @(posedge clk) begin
      bit nxt;
      logic [15:0] exp;
      nxt = word_err(bus_data, bus_par, bus_valid, narrow_bus, even_sense);
      if (rst) begin
         cnt_m = 0; ferr_m = 0; froll_m = 0; snap_m = 0; pend_m = 0;
      end else begin
         if (reg_wr) begin
            if (!reg_wdata[12]) ferr_m = 0;
            if (!reg_wdata[13]) froll_m = 0;
            if (reg_wdata[14]) snap_m = cnt_m;
         end
         if (pend_m) begin
            ferr_m = 1;
            if (cnt_m == 4095) begin cnt_m = 0; froll_m = 1; end
            else cnt_m = cnt_m + 1;
         end
         pend_m = nxt;
      end
      #2;
      exp = {2'b00, froll_m, ferr_m, snap_m[11:0]};
      total++;
      if (reg_rdata !== exp) begin
         bad++;
         $display("FAIL %s t=%0t rdata=%h expected=%h", cur_req, $time, reg_rdata, exp);
      end
   end

   task automatic cyc(input logic [15:0] d, input logic p, input logic v,
                      input logic w, input logic [15:0] wd);
      @(negedge clk);
      bus_data = d; bus_par = p; bus_valid = v; reg_wr = w; reg_wdata = wd;
   endtask

   task automatic word(input logic [15:0] d, input bit good);
      cyc(d, par_for(d, narrow_bus, even_sense, good), 1'b1, 1'b0, 16'h0);
   endtask

   task automatic capture();
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h7000);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cur_req = "R10";
      idle(3);
      @(negedge clk); rst = 1'b0;
      idle(2);

      cur_req = "R1";
      word(16'h0001, 1); word(16'h0003, 0); word(16'hFFFF, 0);
      word(16'h8421, 1); word(16'hA5A5, 0);
      idle(2); capture(); idle(2);

      cur_req = "R2";
      even_sense = 1'b1;
      word(16'h0001, 1); word(16'h00FF, 0); word(16'h1234, 1); word(16'hFFFE, 0);
      idle(2); capture(); idle(2);

      cur_req = "R3";
      narrow_bus = 1'b1;
      for (int i = 0; i < 6; i++) word(16'h5A00 ^ 16'(i * 16'h1101), (i % 2) == 0);
      // upper byte with odd weight but correct low-byte parity: no error
      cyc(16'h0100, 1'b0, 1'b1, 1'b0, 16'h0);
      idle(2); capture(); idle(2);
      narrow_bus = 1'b0;

      cur_req = "R4";
      for (int i = 0; i < 5; i++) cyc(16'h0007, 1'b1, 1'b0, 1'b0, 16'h0);
      idle(1); capture(); idle(2);

      cur_req = "R5";
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h3000);   // keep both flags
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h2000);   // clear error flag
      idle(2);
      word(16'h0002, 0);
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h2000);   // clear coincides with set
      idle(2);

      cur_req = "R8";
      word(16'h0004, 0);
      capture();                                // capture meets pending error
      idle(2); capture(); idle(2);

      cur_req = "R7";
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h3FFF);   // capture bit 0: no snapshot change
      word(16'h0010, 0); idle(2); capture(); idle(2);

      cur_req = "R6";
      for (int i = 0; i < 4096; i++) word(16'(i), 0);
      idle(2); capture(); idle(2);
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'h1000);   // clear rollover only
      idle(2);

      cur_req = "R9";
      cyc(16'h0, 1'b0, 1'b0, 1'b1, 16'hFFFF);
      idle(2);

      cur_req = "R11";
      word(16'h0000, 0); word(16'h0000, 1); idle(1); capture(); idle(2);

      cur_req = "R10";
      word(16'h0001, 0);
      @(negedge clk); rst = 1'b1; bus_valid = 1'b0;
      idle(2);
      @(negedge clk); rst = 1'b0;
      capture(); idle(3);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule